// File: doc/BRIEF.md
# Transactional Read/Write-Set Controller

This block keeps the speculative footprint of one core's hardware transaction on a small direct-mapped tag array. Each line holds a valid bit, a tag, a read mark and a write mark. Transactional loads and stores fill the line and set its mark. Remote coherence probes are compared against these marks to detect conflicts. The block holds no data.

A durable transaction finishes in two steps. It commits only after the end command has been issued and the log unit reports that the redo records are durable. It then reaches commit-complete only when the write-back unit reports that the in-place data is durable. A conflict while active aborts the transaction and discards the written lines.

If a marked line is evicted by a fill, the block raises a sticky overflow flag and does not abort. A begin command that arrives during a transaction is refused and reported.

The lookup outputs are combinational on the request address. The bench can therefore read a line's presence and marks without a clock edge by holding `acc_valid` low.

Top module: `txn_rwset_ctrl`

## Requirements
- R1: While Active, a load sets the read mark and a store sets the write mark of the addressed line, filling the line on a miss. Outside Active, accesses fill lines but set no mark. `look_hit`, `look_rd` and `look_wr` show the state of the line addressed by `acc_addr`. The line index is the low IDX_W bits of the address and the tag is the remaining upper bits.
- R2: `txn_state` uses the codes idle=0, active=1, commit=2, commit-complete=3 and abort=4. Reset gives idle. A begin while idle gives active on the next cycle.
- R3: Active moves to commit on the next cycle only when `log_durable` is high and the end command has been seen (in that cycle or earlier during this transaction). Otherwise the state stays active.
- R4: Commit moves to commit-complete on the cycle after `data_durable` is high, and holds while it is low.
- R5: While Active, any of the following aborts the transaction on the next cycle: a remote write hitting a line with either mark, or a remote read hitting a line with the write mark. A remote read of a read-only line has no effect. A probe that misses has no effect. Probes in any other state are ignored.
- R6: Entering abort invalidates every line holding a write mark and clears all read marks. Read-only lines stay valid.
- R7: Entering commit clears all marks, and the written lines stay valid.
- R8: Commit-complete and abort each return to idle on the following cycle.
- R9: A begin in any state other than idle leaves the state and marks unchanged. It raises `begin_err` for exactly one cycle, on the next cycle.
- R10: A fill that evicts a line holding any mark sets `overflow` on the next cycle without aborting. The flag stays set until the next accepted begin clears it.
- R11: When a conflict and the commit condition occur in the same cycle, abort wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Begin-transaction command |
| tx_end | input | 1 | End-transaction command |
| acc_valid | input | 1 | Local load/store request |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | ADDR_W | Line address of the request; also the lookup address |
| snoop_valid | input | 1 | Remote coherence probe |
| snoop_write | input | 1 | 1 = remote write, 0 = remote read |
| snoop_addr | input | ADDR_W | Line address of the probe |
| log_durable | input | 1 | Log records of the transaction are durable |
| data_durable | input | 1 | In-place data of the transaction is durable |
| txn_state | output | 3 | Transaction state code |
| begin_err | output | 1 | One-cycle pulse for a refused begin |
| overflow | output | 1 | Sticky flag: a marked line was evicted |
| look_hit | output | 1 | Line at `acc_addr` is valid with a matching tag |
| look_rd | output | 1 | That line carries the read mark |
| look_wr | output | 1 | That line carries the write mark |

## Verification
Every state change, `begin_err` pulse and `overflow` update appears one cycle after the edge that samples its cause. Mark and valid changes also take effect at that edge. The lookup outputs are combinational and need no edge. The bench drives inputs one time unit after a rising edge and compares registered outputs one time unit after the next rising edge. It reads the lookup outputs after a short settle with no edge in between. Abort, commit and overflow are each checked both in the state code and in the line contents they leave behind.

// File: rtl/txn_rwset_ctrl.sv
module txn_rwset_ctrl #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin,
  input  logic              tx_end,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              snoop_valid,
  input  logic              snoop_write,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              log_durable,
  input  logic              data_durable,
  output logic [2:0]        txn_state,
  output logic              begin_err,
  output logic              overflow,
  output logic              look_hit,
  output logic              look_rd,
  output logic              look_wr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_ACTIVE = 3'd1, S_COMMIT = 3'd2, S_CDONE = 3'd3, S_ABORT = 3'd4
  } st_t;

  st_t              st_q;
  logic             end_seen_q;
  logic [LINES-1:0] vld_q, rm_q, wm_q;
  logic [TAG_W-1:0] tag_q [LINES];

  wire [IDX_W-1:0] a_idx = acc_addr[IDX_W-1:0];
  wire [TAG_W-1:0] a_tag = acc_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snoop_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snoop_addr[ADDR_W-1:IDX_W];

  wire active   = (st_q == S_ACTIVE);
  wire s_hit    = vld_q[s_idx] && (tag_q[s_idx] == s_tag);
  wire s_marked = snoop_write ? (rm_q[s_idx] | wm_q[s_idx]) : wm_q[s_idx];
  wire conflict = active && snoop_valid && s_hit && s_marked;
  wire go_commit = active && !conflict && (end_seen_q || tx_end) && log_durable;
  wire acc_go   = acc_valid && !conflict && !go_commit;
  wire spill    = acc_go && !look_hit && vld_q[a_idx] && (rm_q[a_idx] | wm_q[a_idx]);

  assign look_hit  = vld_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign look_rd   = look_hit && rm_q[a_idx];
  assign look_wr   = look_hit && wm_q[a_idx];
  assign txn_state = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      end_seen_q <= 1'b0;
      begin_err  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      begin_err <= tx_begin && (st_q != S_IDLE);
      if (spill) overflow <= 1'b1;
      unique case (st_q)
        S_IDLE: if (tx_begin) begin
          st_q       <= S_ACTIVE;
          end_seen_q <= 1'b0;
          overflow   <= 1'b0;
        end
        S_ACTIVE: begin
          if (tx_end) end_seen_q <= 1'b1;
          if (conflict)       st_q <= S_ABORT;
          else if (go_commit) st_q <= S_COMMIT;
        end
        S_COMMIT: if (data_durable) st_q <= S_CDONE;
        S_CDONE:  st_q <= S_IDLE;
        S_ABORT:  st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      rm_q  <= '0;
      wm_q  <= '0;
    end else if (conflict) begin
      vld_q <= vld_q & ~wm_q;
      rm_q  <= '0;
      wm_q  <= '0;
    end else if (go_commit) begin
      rm_q <= '0;
      wm_q <= '0;
    end else if (acc_go) begin
      if (!look_hit) begin
        vld_q[a_idx] <= 1'b1;
        rm_q[a_idx]  <= active && !acc_write;
        wm_q[a_idx]  <= active && acc_write;
      end else if (active) begin
        if (acc_write) wm_q[a_idx] <= 1'b1;
        else           rm_q[a_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_go && !look_hit) tag_q[a_idx] <= a_tag;
  end
endmodule

// File: rtl/txn_rwset_chk.sv
module txn_rwset_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_begin,
  input logic       log_durable,
  input logic       data_durable,
  input logic [2:0] txn_state,
  input logic       begin_err,
  input logic       overflow
);
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    txn_state <= 3'd4);

  a_r2_begin: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == 3'd0 && tx_begin) |=> txn_state == 3'd1);

  a_r3_needs_log: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == 3'd1 && !log_durable) |=> txn_state != 3'd2);

  a_r4_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == 3'd2 && data_durable) |=> txn_state == 3'd3);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == 3'd2 && !data_durable) |=> txn_state == 3'd2);

  a_r8_return: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_state == 3'd3 || txn_state == 3'd4) |=> txn_state == 3'd0);

  a_r9_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_begin && txn_state != 3'd0) |=> (begin_err && $stable(txn_state)) || txn_state == 3'd0);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !(txn_state == 3'd0 && tx_begin)) |=> overflow);
endmodule

bind txn_rwset_ctrl txn_rwset_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .log_durable(log_durable),
  .data_durable(data_durable), .txn_state(txn_state), .begin_err(begin_err),
  .overflow(overflow)
);

// File: tb/sim_txn_rwset_ctrl.sv
module sim_txn_rwset_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_begin = 0, tx_end = 0, acc_valid = 0, acc_write = 0;
  logic snoop_valid = 0, snoop_write = 0, log_durable = 0, data_durable = 0;
  logic [11:0] acc_addr = '0, snoop_addr = '0;
  logic [2:0] txn_state;
  logic begin_err, overflow, look_hit, look_rd, look_wr;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  txn_rwset_ctrl u0 (.*);

  // req | beg end av aw | acc_addr | sv sw | snoop_addr | log data | exp_state
  localparam int NV = 25;
  localparam logic [38:0] VEC [NV] = '{
    {4'd2,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd0}, // R2 idle holds
    {4'd2,  4'b1000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1}, // R2 begin
    {4'd1,  4'b0010, 12'h010, 2'b00, 12'h000, 2'b00, 3'd1}, // R1 load
    {4'd1,  4'b0011, 12'h021, 2'b00, 12'h000, 2'b00, 3'd1}, // R1 store
    {4'd3,  4'b0100, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1}, // R3 end, no log
    {4'd3,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1}, // R3 waiting
    {4'd3,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b10, 3'd2}, // R3 log durable
    {4'd4,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd2}, // R4 hold
    {4'd5,  4'b0000, 12'h000, 2'b11, 12'h021, 2'b00, 3'd2}, // R5 probe in commit ignored
    {4'd4,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b01, 3'd3}, // R4 data durable
    {4'd8,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd0}, // R8
    {4'd2,  4'b1000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd1,  4'b0011, 12'h032, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd5,  4'b0000, 12'h000, 2'b10, 12'h032, 2'b00, 3'd4}, // R5 read of W line
    {4'd8,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd0}, // R8
    {4'd2,  4'b1000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd1,  4'b0010, 12'h043, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd5,  4'b0000, 12'h000, 2'b10, 12'h043, 2'b00, 3'd1}, // R5 read of R line
    {4'd5,  4'b0000, 12'h000, 2'b11, 12'h143, 2'b00, 3'd1}, // R5 tag miss
    {4'd5,  4'b0000, 12'h000, 2'b11, 12'h043, 2'b00, 3'd4}, // R5 write of R line
    {4'd8,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd0},
    {4'd2,  4'b1000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd1,  4'b0011, 12'h054, 2'b00, 12'h000, 2'b00, 3'd1},
    {4'd11, 4'b0100, 12'h000, 2'b10, 12'h054, 2'b10, 3'd4}, // R11 abort beats commit
    {4'd8,  4'b0000, 12'h000, 2'b00, 12'h000, 2'b00, 3'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    tx_begin = 0; tx_end = 0; acc_valid = 0; acc_write = 0;
    snoop_valid = 0; snoop_write = 0; log_durable = 0; data_durable = 0;
  endtask

  task automatic probe(input logic [11:0] a, input bit eh, input bit er, input bit ew, input string req);
    acc_valid = 0; acc_addr = a;
    #1;
    chk(look_hit == eh, req, int'(look_hit), int'(eh));
    chk(look_rd == er, req, int'(look_rd), int'(er));
    chk(look_wr == ew, req, int'(look_wr), int'(ew));
  endtask

  task automatic access(input logic [11:0] a, input bit wr);
    acc_valid = 1; acc_write = wr; acc_addr = a;
    tick();
    idle_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    // reset state (R2, R10)
    chk(txn_state == 3'd0, "R2 reset", int'(txn_state), 0);
    chk(begin_err == 1'b0, "R9 reset", int'(begin_err), 0);
    chk(overflow == 1'b0, "R10 reset", int'(overflow), 0);
    probe(12'h000, 0, 0, 0, "R1 reset empty");

    for (int i = 0; i < NV; i++) begin
      logic [38:0] v;
      v = VEC[i];
      tx_begin = v[34]; tx_end = v[33]; acc_valid = v[32]; acc_write = v[31];
      acc_addr = v[30:19]; snoop_valid = v[18]; snoop_write = v[17];
      snoop_addr = v[16:5]; log_durable = v[4]; data_durable = v[3];
      tick();
      idle_in();
      chk(txn_state == v[2:0], $sformatf("R%0d vector %0d", v[38:35], i),
          int'(txn_state), int'(v[2:0]));
    end

    // R1 marks during a transaction
    tx_begin = 1; tick(); idle_in();
    access(12'h065, 0);
    access(12'h076, 1);
    probe(12'h065, 1, 1, 0, "R1 load mark");
    probe(12'h076, 1, 0, 1, "R1 store mark");

    // R9 refused begin
    tx_begin = 1; tick(); idle_in();
    chk(begin_err == 1'b1, "R9 pulse", int'(begin_err), 1);
    chk(txn_state == 3'd1, "R9 state kept", int'(txn_state), 1);
    tick();
    chk(begin_err == 1'b0, "R9 one cycle", int'(begin_err), 0);
    probe(12'h065, 1, 1, 0, "R9 marks kept");

    // R10 eviction of a marked line
    access(12'h165, 0);
    chk(overflow == 1'b1, "R10 set", int'(overflow), 1);
    chk(txn_state == 3'd1, "R10 no abort", int'(txn_state), 1);
    probe(12'h165, 1, 1, 0, "R10 new line");

    // R7 commit clears marks, keeps lines
    tx_end = 1; log_durable = 1; tick(); idle_in();
    chk(txn_state == 3'd2, "R7 commit", int'(txn_state), 2);
    probe(12'h076, 1, 0, 0, "R7 written line kept");
    chk(overflow == 1'b1, "R10 sticky", int'(overflow), 1);
    data_durable = 1; tick(); idle_in();
    tick();
    tx_begin = 1; tick(); idle_in();
    chk(overflow == 1'b0, "R10 cleared by begin", int'(overflow), 0);

    // R6 abort invalidates written lines only
    access(12'h087, 1);
    access(12'h098, 0);
    snoop_valid = 1; snoop_write = 1; snoop_addr = 12'h098; tick(); idle_in();
    chk(txn_state == 3'd4, "R6 abort", int'(txn_state), 4);
    probe(12'h087, 0, 0, 0, "R6 write line dropped");
    probe(12'h098, 1, 0, 0, "R6 read line kept");
    tick();

    // R1 idle access fills without marks
    access(12'h0A9, 1);
    probe(12'h0A9, 1, 0, 0, "R1 idle no mark");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule